// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Resolver

This block turns an inter-processor interrupt command into a set of receiving processor units. Software writes the command in two 32-bit halves: the upper half holds the destination identifier, the lower half holds the vector, the delivery type, the addressing model and a shorthand selector. A write of the lower half launches the send. The resolver evaluates the destination against every unit's physical ID, its logical ID and its logical format nibble. It then registers a one-cycle delivery pulse that carries an N-bit target mask and the delivery parameters.

Each unit supplies three items: a presence flag, an 8-bit physical ID, and an 8-bit logical ID with a 4-bit format nibble. The logical ID and format nibble are bits 31:24 and 31:28 of that unit's logical-destination and format registers. The shorthand selector overrides the destination field completely. A lowest-priority send goes to a single unit. An INIT de-assert command produces no delivery pulse. Instead it loads each targeted unit's physical ID into its arbitration ID, which is held in this block and driven out.

Top module: `ipi_dest_resolver`

## Requirements
- R1: While reset is asserted and after its release, `dlv_valid` is low and every arbitration ID reads 0x00 until a command changes them.
- R2: A write to the upper half only stores bits 31:24 as the destination ID and produces no pulse. A write to the lower half raises `dlv_valid` for exactly one cycle, in the cycle after the write. The pulse carries vector = bits 7:0, delivery type = bits 10:8 and trigger = bit 15, and uses the destination stored by earlier upper-half writes.
- R3: Shorthand (lower bits 19:18) overrides the destination and addressing model. Code 1 targets only the unit at `sender_idx`. Code 2 targets all units. Code 3 targets all units except `sender_idx`.
- R4: With shorthand 0 and physical addressing (bit 11 = 0), destination 0xFF targets every unit. Any other destination targets each unit whose physical ID equals it.
- R5: With shorthand 0 and logical addressing (bit 11 = 1), a unit with format nibble 0xF matches when the destination ANDed with its logical ID is nonzero.
- R6: With logical addressing, a unit with format nibble 0x0 matches when the upper nibbles of the destination and its logical ID are equal and their lower nibbles have at least one set bit in common.
- R7: With logical addressing, a unit whose format nibble is neither 0xF nor 0x0 never matches.
- R8: With delivery type 3'b001 (lowest priority), the mask holds only the lowest-indexed unit of the resolved set, or is empty if the set is empty.
- R9: A lower-half write with delivery type 3'b101, level (bit 14) 0 and trigger 1 produces no pulse. In the next cycle, each targeted unit's arbitration ID equals its physical ID, and all other arbitration IDs are unchanged. Arbitration IDs change on no other command.
- R10: A unit whose presence flag is 0 is never set in `dlv_mask` and never has its arbitration ID loaded. A send that resolves to no unit still pulses, with an empty mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_lo_we | input | 1 | Write strobe for the lower command half (launches a send) |
| cmd_hi_we | input | 1 | Write strobe for the upper command half (stores destination) |
| cmd_wdata | input | 32 | Write data for either command half |
| sender_idx | input | IDX_W | Index of the unit issuing the command |
| unit_present | input | N | Per-unit presence flags |
| unit_id_flat | input | N*8 | Physical IDs, unit i at bits 8i+7:8i |
| unit_logid_flat | input | N*8 | Logical IDs, unit i at bits 8i+7:8i |
| unit_fmt_flat | input | N*4 | Logical format nibbles, unit i at bits 4i+3:4i |
| dlv_valid | output | 1 | One-cycle delivery pulse |
| dlv_mask | output | N | Target units of the delivery |
| dlv_vector | output | 8 | Delivered vector |
| dlv_mode | output | 3 | Delivered delivery type |
| dlv_trigger | output | 1 | Delivered trigger mode |
| arb_id_flat | output | N*8 | Arbitration IDs, unit i at bits 8i+7:8i |

## Verification
The hardest case to reach is one where two addressing rules disagree about the same unit. An example is a logical destination that hits flat-format units through their bit overlap while also hitting cluster-format units through the nibble rule, with a third, unknown format that would match under either rule if it were honoured. The stimulus uses a fixed population of flat, cluster, unknown-format and absent units, and sends destinations chosen so that each rule selects a different subset. The INIT de-assert path is observed only through the arbitration IDs, so the bench first loads a single unit's ID through the self shorthand and then loads all of them through a broadcast. This shows that units outside the target set keep their old value.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam logic [7:0] DEST_BROADCAST = 8'hFF;
    localparam logic [3:0] FMT_FLAT       = 4'hF;
    localparam logic [3:0] FMT_CLUSTER    = 4'h0;

    typedef enum logic [2:0] {
        DM_FIXED   = 3'b000,
        DM_LOWEST  = 3'b001,
        DM_SMI     = 3'b010,
        DM_RSVD    = 3'b011,
        DM_NMI     = 3'b100,
        DM_INIT    = 3'b101,
        DM_STARTUP = 3'b110,
        DM_EXTINT  = 3'b111
    } dmode_e;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [7:0] vector;
        dmode_e     mode;
        logic       logical;
        logic       level;
        logic       trigger;
        shorthand_e sh;
    } cmd_t;

    // Field positions of the lower command half.
    function automatic cmd_t decode_cmd(input logic [31:0] w);
        cmd_t c;
        c.vector  = w[7:0];
        c.mode    = dmode_e'(w[10:8]);
        c.logical = w[11];
        c.level   = w[14];
        c.trigger = w[15];
        c.sh      = shorthand_e'(w[19:18]);
        return c;
    endfunction

endpackage

// File: rtl/ipi_unit_match.sv
// Per-unit destination comparison for shorthand 0.
module ipi_unit_match
    import ipi_pkg::*;
(
    input  logic [7:0] dest_id,
    input  logic       logical,
    input  logic [7:0] unit_id,
    input  logic [7:0] unit_logid,
    input  logic [3:0] unit_fmt,
    output logic       hit
);

    logic phys_hit;
    logic flat_hit;
    logic clus_hit;

    always_comb begin
        phys_hit = (dest_id == DEST_BROADCAST) || (dest_id == unit_id);
        flat_hit = |(dest_id & unit_logid);
        clus_hit = (dest_id[7:4] == unit_logid[7:4]) &&
                   (|(dest_id[3:0] & unit_logid[3:0]));
        if (!logical) begin
            hit = phys_hit;
        end else begin
            unique case (unit_fmt)
                FMT_FLAT:    hit = flat_hit;
                FMT_CLUSTER: hit = clus_hit;
                default:     hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ipi_shorthand_mask.sv
// Applies the shorthand selector and the presence flags.
module ipi_shorthand_mask
    import ipi_pkg::*;
#(
    parameter  int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  shorthand_e       sh,
    input  logic [IDX_W-1:0] sender_idx,
    input  logic [N-1:0]     dest_hits,
    input  logic [N-1:0]     present,
    output logic [N-1:0]     mask
);

    logic [N-1:0] self_sel;
    logic [N-1:0] raw;

    for (genvar g = 0; g < N; g++) begin : g_self
        assign self_sel[g] = (sender_idx == IDX_W'(g));
    end

    always_comb begin
        unique case (sh)
            SH_NONE:   raw = dest_hits;
            SH_SELF:   raw = self_sel;
            SH_ALL:    raw = '1;
            SH_OTHERS: raw = ~self_sel;
            default:   raw = '0;
        endcase
        mask = raw & present;
    end

endmodule

// File: rtl/ipi_lowest_pick.sv
// Keeps only the lowest-indexed set bit.
module ipi_lowest_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] mask_in,
    output logic [N-1:0] mask_out
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign mask_out[g] = mask_in[g] & ~seen[g];
        assign seen[g+1]   = seen[g] | mask_in[g];
    end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
    import ipi_pkg::*;
#(
    parameter  int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_lo_we,
    input  logic               cmd_hi_we,
    input  logic [31:0]        cmd_wdata,
    input  logic [IDX_W-1:0]   sender_idx,
    input  logic [N-1:0]       unit_present,
    input  logic [N*8-1:0]     unit_id_flat,
    input  logic [N*8-1:0]     unit_logid_flat,
    input  logic [N*4-1:0]     unit_fmt_flat,
    output logic               dlv_valid,
    output logic [N-1:0]       dlv_mask,
    output logic [7:0]         dlv_vector,
    output logic [2:0]         dlv_mode,
    output logic               dlv_trigger,
    output logic [N*8-1:0]     arb_id_flat
);

    typedef struct packed {
        logic                valid;
        logic [N-1:0]        mask;
        logic [7:0]          vector;
        logic [2:0]          mode;
        logic                trigger;
        logic [7:0]          dest_id;
        logic [N-1:0][7:0]   arb_id;
    } state_t;

    state_t s_d;
    state_t s_q;

    cmd_t         cmd_c;
    logic [N-1:0] hit_c;
    logic [N-1:0] route_c;
    logic [N-1:0] pick_c;
    logic [N-1:0] final_c;
    logic         init_deassert_c;

    assign cmd_c = decode_cmd(cmd_wdata);

    for (genvar g = 0; g < N; g++) begin : g_unit
        ipi_unit_match i_match (
            .dest_id    (s_q.dest_id),
            .logical    (cmd_c.logical),
            .unit_id    (unit_id_flat[g*8 +: 8]),
            .unit_logid (unit_logid_flat[g*8 +: 8]),
            .unit_fmt   (unit_fmt_flat[g*4 +: 4]),
            .hit        (hit_c[g])
        );
    end

    ipi_shorthand_mask #(.N(N)) i_shorthand (
        .sh         (cmd_c.sh),
        .sender_idx (sender_idx),
        .dest_hits  (hit_c),
        .present    (unit_present),
        .mask       (route_c)
    );

    ipi_lowest_pick #(.N(N)) i_pick (
        .mask_in  (route_c),
        .mask_out (pick_c)
    );

    assign final_c         = (cmd_c.mode == DM_LOWEST) ? pick_c : route_c;
    assign init_deassert_c = (cmd_c.mode == DM_INIT) && !cmd_c.level && cmd_c.trigger;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (cmd_hi_we) begin
            s_d.dest_id = cmd_wdata[31:24];
        end
        if (cmd_lo_we) begin
            if (init_deassert_c) begin
                for (int i = 0; i < N; i++) begin
                    if (final_c[i]) begin
                        s_d.arb_id[i] = unit_id_flat[i*8 +: 8];
                    end
                end
            end else begin
                s_d.valid   = 1'b1;
                s_d.mask    = final_c;
                s_d.vector  = cmd_c.vector;
                s_d.mode    = cmd_c.mode;
                s_d.trigger = cmd_c.trigger;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dlv_valid   = s_q.valid;
    assign dlv_mask    = s_q.mask;
    assign dlv_vector  = s_q.vector;
    assign dlv_mode    = s_q.mode;
    assign dlv_trigger = s_q.trigger;
    assign arb_id_flat = s_q.arb_id;

endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
    parameter  int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_lo_we,
    input logic [31:0]      cmd_wdata,
    input logic [IDX_W-1:0] sender_idx,
    input logic [N-1:0]     unit_present,
    input logic             dlv_valid,
    input logic [N-1:0]     dlv_mask,
    input logic [2:0]       dlv_mode,
    input logic [N*8-1:0]   arb_id_flat
);

    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> $past(cmd_lo_we)) else $error("pulse without write"); // R2

    AST_MASK_ONLY_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ((dlv_mask & ~$past(unit_present)) == '0)) else $error("absent unit targeted"); // R10

    AST_LOWEST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_mode == 3'b001) |-> $onehot0(dlv_mask)) else $error("lowest mode multi-target"); // R8

    AST_INIT_DEASSERT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lo_we && cmd_wdata[10:8] == 3'b101 && !cmd_wdata[14] && cmd_wdata[15])
        |=> !dlv_valid) else $error("init de-assert pulsed"); // R9

    AST_ARB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_lo_we |=> $stable(arb_id_flat)) else $error("arb id changed"); // R9

    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lo_we && cmd_wdata[19:18] == 2'd1 && cmd_wdata[10:8] != 3'b101)
        |=> ((dlv_mask & ~(N'(1) << $past(sender_idx))) == '0)) else $error("self shorthand leak"); // R3

endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.N(N)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_lo_we    (cmd_lo_we),
    .cmd_wdata    (cmd_wdata),
    .sender_idx   (sender_idx),
    .unit_present (unit_present),
    .dlv_valid    (dlv_valid),
    .dlv_mask     (dlv_mask),
    .dlv_mode     (dlv_mode),
    .arb_id_flat  (arb_id_flat)
);

// File: tb/test_ipi_dest_resolver.sv
module test_ipi_dest_resolver;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_lo_we = 1'b0;
    logic          cmd_hi_we = 1'b0;
    logic [31:0]   cmd_wdata = '0;
    logic [2:0]    sender_idx = 3'd2;
    logic [N-1:0]  unit_present;
    logic [N*8-1:0] unit_id_flat;
    logic [N*8-1:0] unit_logid_flat;
    logic [N*4-1:0] unit_fmt_flat;
    logic          dlv_valid;
    logic [N-1:0]  dlv_mask;
    logic [7:0]    dlv_vector;
    logic [2:0]    dlv_mode;
    logic          dlv_trigger;
    logic [N*8-1:0] arb_id_flat;

    always #4 clk = ~clk;

    ipi_dest_resolver #(.N(N)) i_ipi_dest_resolver (
        .clk(clk), .rst_n(rst_n), .cmd_lo_we(cmd_lo_we), .cmd_hi_we(cmd_hi_we),
        .cmd_wdata(cmd_wdata), .sender_idx(sender_idx), .unit_present(unit_present),
        .unit_id_flat(unit_id_flat), .unit_logid_flat(unit_logid_flat),
        .unit_fmt_flat(unit_fmt_flat), .dlv_valid(dlv_valid), .dlv_mask(dlv_mask),
        .dlv_vector(dlv_vector), .dlv_mode(dlv_mode), .dlv_trigger(dlv_trigger),
        .arb_id_flat(arb_id_flat)
    );

    // Unit population: 0-3 flat, 4-5 cluster, 6 unknown format, 7 absent.
    logic [7:0] pid [N];
    logic [7:0] lid [N];
    logic [3:0] fmt [N];
    logic [7:0] stored_dest = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;
    logic [19:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] vec, input logic [2:0] mode,
                                       input bit logical, input bit lvl, input bit trig,
                                       input logic [1:0] sh);
        return {12'h000, sh, 2'b00, trig, lvl, 2'b00, logical, mode, vec};
    endfunction

    // Reference target set built from the requirements.
    function automatic logic [7:0] model_mask(input logic [31:0] w);
        logic [7:0] m = '0;
        logic [7:0] d = stored_dest;
        for (int i = 0; i < N; i++) begin
            bit h = 0;
            case (w[19:18])
                2'd0: begin
                    if (!w[11]) h = (d == 8'hFF) || (d == pid[i]);
                    else if (fmt[i] == 4'hF) h = (d & lid[i]) != 0;
                    else if (fmt[i] == 4'h0) h = (d[7:4] == lid[i][7:4]) && ((d[3:0] & lid[i][3:0]) != 0);
                end
                2'd1: h = (i == int'(sender_idx));
                2'd2: h = 1;
                default: h = (i != int'(sender_idx));
            endcase
            m[i] = h && unit_present[i];
        end
        if (w[10:8] == 3'b001) begin
            for (int i = 0; i < N; i++) begin
                if (m[i]) begin
                    m = 8'(1) << i;
                    break;
                end
            end
        end
        return m;
    endfunction

    task automatic send(input logic [31:0] w, input string tag);
        @(negedge clk);
        cmd_wdata = w;
        cmd_lo_we = 1'b1;
        exp_q.push_back({model_mask(w), w[7:0], w[10:8], w[15]});
        tag_q.push_back(tag);
    endtask

    task automatic send_silent(input logic [31:0] w);
        @(negedge clk);
        cmd_wdata = w;
        cmd_lo_we = 1'b1;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cmd_lo_we = 1'b0;
        cmd_hi_we = 1'b0;
        repeat (n) @(negedge clk);
        chk(exp_q.size() == 0, "R2 missing pulse", 32'(exp_q.size()), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic write_hi(input logic [7:0] d);
        @(negedge clk);
        cmd_wdata = {d, 24'h00_0000};
        cmd_hi_we = 1'b1;
        stored_dest = d;
        @(negedge clk);
        cmd_hi_we = 1'b0;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && dlv_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected pulse", {24'h0, dlv_mask}, 0);
            end else begin
                logic [19:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({dlv_mask, dlv_vector, dlv_mode, dlv_trigger} == e, t,
                    {12'h0, dlv_mask, dlv_vector, dlv_mode, dlv_trigger}, {12'h0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            pid[i] = 8'h20 + 8'(i);
            lid[i] = 8'(1) << i;
            fmt[i] = 4'hF;
        end
        lid[4] = 8'h31; fmt[4] = 4'h0;
        lid[5] = 8'h32; fmt[5] = 4'h0;
        lid[6] = 8'h33; fmt[6] = 4'h8;
        unit_present = 8'b0111_1111;
        for (int i = 0; i < N; i++) begin
            unit_id_flat[i*8 +: 8]    = pid[i];
            unit_logid_flat[i*8 +: 8] = lid[i];
            unit_fmt_flat[i*4 +: 4]   = fmt[i];
        end

        repeat (3) @(negedge clk);
        chk(dlv_valid == 1'b0, "R1 valid in reset", 32'(dlv_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dlv_valid == 1'b0, "R1 valid after reset", 32'(dlv_valid), 0);
        chk(arb_id_flat == '0, "R1 arb ids", arb_id_flat[31:0], 0);

        // R2: upper half only stores, no pulse (monitor flags any pulse)
        write_hi(8'h23);
        idle(2);

        // R4 physical single and broadcast; R10 absent target
        send(mk(8'h41, 3'b000, 0, 0, 0, 2'd0), "R4 physical id 0x23");
        idle(2);
        write_hi(8'hFF);
        send(mk(8'h42, 3'b100, 0, 0, 1, 2'd0), "R4 R10 physical broadcast");
        idle(2);
        write_hi(8'h27);
        send(mk(8'h43, 3'b000, 0, 0, 0, 2'd0), "R10 absent unit empty mask");
        idle(2);

        // R5 flat, R6 cluster, R7 unknown format
        write_hi(8'h05);
        send(mk(8'h50, 3'b000, 1, 0, 0, 2'd0), "R5 logical flat");
        idle(2);
        write_hi(8'h33);
        send(mk(8'h51, 3'b000, 1, 0, 1, 2'd0), "R6 R7 logical cluster and flat");
        idle(2);
        write_hi(8'h34);
        send(mk(8'h52, 3'b000, 1, 0, 0, 2'd0), "R6 cluster no bit overlap");
        idle(2);

        // R8 lowest priority
        write_hi(8'h33);
        send(mk(8'h60, 3'b001, 1, 0, 0, 2'd0), "R8 lowest logical");
        idle(2);
        write_hi(8'h30);
        send(mk(8'h61, 3'b001, 1, 0, 0, 2'd0), "R8 lowest empty set");
        idle(2);

        // R3 shorthands, back to back, overriding a logical destination
        send(mk(8'h70, 3'b000, 1, 0, 0, 2'd1), "R3 self");
        send(mk(8'h71, 3'b000, 1, 0, 0, 2'd2), "R3 all");
        send(mk(8'h72, 3'b000, 0, 0, 0, 2'd3), "R3 others");
        idle(2);
        sender_idx = 3'd7;
        send(mk(8'h73, 3'b000, 0, 0, 0, 2'd1), "R3 R10 self absent");
        send(mk(8'h74, 3'b001, 0, 0, 0, 2'd3), "R3 R8 others lowest");
        idle(2);
        sender_idx = 3'd2;

        // R9: INIT assert pulses normally and leaves arb ids alone
        send(mk(8'h00, 3'b101, 0, 1, 1, 2'd2), "R9 init assert pulses");
        idle(2);
        chk(arb_id_flat == '0, "R9 arb after init assert", arb_id_flat[31:0], 0);
        // R9: de-assert to self only
        send_silent(mk(8'h00, 3'b101, 0, 0, 1, 2'd1));
        idle(2);
        chk(arb_id_flat == {40'h0, 8'h22, 16'h0}, "R9 arb self load",
            arb_id_flat[31:0], 32'h0022_0000);
        // R9 R10: de-assert broadcast
        write_hi(8'hFF);
        send_silent(mk(8'h00, 3'b101, 0, 0, 1, 2'd0));
        idle(2);
        for (int i = 0; i < N; i++) begin
            logic [7:0] e;
            e = unit_present[i] ? pid[i] : 8'h00;
            chk(arb_id_flat[i*8 +: 8] == e, "R9 R10 arb broadcast load",
                32'(arb_id_flat[i*8 +: 8]), 32'(e));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule